// File: doc/BRIEF.md
# Raster frame timing generator

This block is the beam position counter of a raster picture processor. On every pixel clock it advances a horizontal dot index and, when a line is finished, a scanline index. It tells the rest of the picture pipeline which part of the frame is being scanned: active picture lines, the single idle line after the picture, the vertical-blank lines, and the preparation line that closes each frame.

The same counters drive the frame status timing. A vertical-blank status flag is set one dot into the first blank line. It is cleared one dot into the preparation line. A one-cycle strobe tells the sprite logic to drop its overflow and hit flags on the cycle the blank flag falls. A CPU-side read of the status register pulses a clear input, which drops the blank flag at once and leaves the counters alone.

A frame-parity bit flips on each frame wrap. On frames of odd parity, when rendering is enabled, the preparation line ends one dot early, so the frame is one pixel clock shorter. Dimensions and the flag dot are parameters, and the short-frame behaviour can be removed with a parameter.

Top module: `raster_timing_gen`

## Requirements
- R1: `dot` counts up by one per clock from 0 to DOTS_PER_LINE-1 (default 341 dots, so the last index is 340) and then returns to 0.
- R2: `line` increments when `dot` wraps to 0 and runs 0 to LINES_PER_FRAME-1 (default 262). After the last line it returns to 0.
- R3: While `rst_n` is low, `line` holds the preparation line (LINES_PER_FRAME-1), and `dot`, `odd_frame` and `vblank_flag` are 0.
- R4: Exactly one region strobe is high at any time, decoded from `line`:
  - `rgn_visible` for lines below VISIBLE_LINES (default 240);
  - `rgn_post` for line VISIBLE_LINES;
  - `rgn_vblank` for lines VISIBLE_LINES+1 to LINES_PER_FRAME-2;
  - `rgn_pre` for line LINES_PER_FRAME-1.
- R5: `vblank_flag` becomes 1 on the same clock that the counters reach line VISIBLE_LINES+1, dot FLAG_DOT (default 1). It never rises at any other position.
- R6: `vblank_flag` becomes 0 on the same clock that the counters reach the preparation line at dot FLAG_DOT.
- R7: `sprite_flags_clr` is 1 exactly while the counters show the preparation line at dot FLAG_DOT, and is 0 otherwise.
- R8: `odd_frame` inverts each time the counters wrap from the preparation line to line 0. It is 0 during the first frame after reset.
- R9: When `odd_frame` is 1 and `render_en` is 1 while the counters show the preparation line at dot DOTS_PER_LINE-2, the next position is line 0, dot 0.
- R10: When `odd_frame` is 0 or `render_en` is 0 at that position, the counters go on to dot DOTS_PER_LINE-1 and wrap one clock later.
- R11: A 1 on `status_rd_clr` makes `vblank_flag` read 0 after the next clock edge. It never changes `dot`, `line` or `odd_frame`.
- R12: If `status_rd_clr` is 1 on the edge where the blank flag is set (R5), the set wins and `vblank_flag` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| render_en | input | 1 | Rendering enabled; gates the odd-frame short line |
| status_rd_clr | input | 1 | One-cycle pulse from a status read; clears the blank flag |
| dot | output | clog2(DOTS_PER_LINE) | Current dot index |
| line | output | clog2(LINES_PER_FRAME) | Current scanline index |
| odd_frame | output | 1 | Frame parity, 1 on odd frames |
| rgn_visible | output | 1 | Current line is a picture line |
| rgn_post | output | 1 | Current line is the idle line after the picture |
| rgn_vblank | output | 1 | Current line is a vertical-blank line |
| rgn_pre | output | 1 | Current line is the preparation line |
| vblank_flag | output | 1 | Vertical-blank status flag |
| sprite_flags_clr | output | 1 | Strobe that clears the sprite overflow and hit flags |

## Verification
The properties assume that `render_en` and `status_rd_clr` are ordinary synchronous levels, that they change only away from the clock edge, and that reset is held for at least one edge before counting starts. The bench changes its inputs on the falling edge.

It switches `render_en` every two frames, so odd frames occur both with and without the short line. It places clear pulses on a fixed period, plus two placed on purpose: one on the very edge where the flag is set, and one a few dots after it.

Because the run uses a reduced frame size, every position of every frame is compared against an arithmetic model.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   // Part of the frame the beam is in, decoded from the line index.
   typedef enum logic [1:0] {
      RGN_VISIBLE = 2'd0,
      RGN_POST    = 2'd1,
      RGN_VBLANK  = 2'd2,
      RGN_PRE     = 2'd3
   } region_e;

endpackage

// File: rtl/rtg_beam_counter.sv
// Dot and line counters with the optional short preparation line.
module rtg_beam_counter #(
   parameter int DOTS     = 341,
   parameter int LINES    = 262,
   parameter bit SKIP_ODD = 1'b1,
   parameter int DW       = $clog2(DOTS),
   parameter int LW       = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          render_en,
   output logic [DW-1:0] dot_q,
   output logic [LW-1:0] line_q,
   output logic          odd_q,
   output logic [DW-1:0] dot_n,
   output logic [LW-1:0] line_n
);

   localparam logic [DW-1:0] LAST_DOT  = DW'(DOTS - 1);
   localparam logic [DW-1:0] SHORT_DOT = DW'(DOTS - 2);
   localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

   logic skip;
   logic odd_n;

   // Variant choice: with SKIP_ODD the preparation line of an odd,
   // rendering frame ends one dot early.
   generate
      if (SKIP_ODD) begin : g_skip
         assign skip = (line_q == LAST_LINE) && (dot_q == SHORT_DOT)
                       && odd_q && render_en;
      end else begin : g_noskip
         assign skip = 1'b0;
      end
   endgenerate

   always_comb begin
      dot_n  = dot_q + 1'b1;
      line_n = line_q;
      odd_n  = odd_q;
      if (skip || dot_q == LAST_DOT) begin
         dot_n = '0;
         if (line_q == LAST_LINE) begin
            line_n = '0;
            odd_n  = ~odd_q;
         end else begin
            line_n = line_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dot_q  <= '0;
         line_q <= LAST_LINE;
         odd_q  <= 1'b0;
      end else begin
         dot_q  <= dot_n;
         line_q <= line_n;
         odd_q  <= odd_n;
      end
   end

endmodule

// File: rtl/rtg_region_decode.sv
// Decodes the line index into the four frame regions.
module rtg_region_decode
   import rtg_pkg::*;
#(
   parameter int LINES   = 262,
   parameter int VISIBLE = 240,
   parameter int LW      = $clog2(LINES)
) (
   input  logic [LW-1:0] line_q,
   output region_e       region,
   output logic          is_visible,
   output logic          is_post,
   output logic          is_vblank,
   output logic          is_pre
);

   localparam logic [LW-1:0] POST_LINE = LW'(VISIBLE);
   localparam logic [LW-1:0] PRE_LINE  = LW'(LINES - 1);

   always_comb begin
      if (line_q < POST_LINE)       region = RGN_VISIBLE;
      else if (line_q == POST_LINE) region = RGN_POST;
      else if (line_q == PRE_LINE)  region = RGN_PRE;
      else                          region = RGN_VBLANK;
   end

   assign is_visible = (region == RGN_VISIBLE);
   assign is_post    = (region == RGN_POST);
   assign is_vblank  = (region == RGN_VBLANK);
   assign is_pre     = (region == RGN_PRE);

endmodule

// File: rtl/rtg_status_flags.sv
// Blank flag and the sprite-flag clear strobe, timed from the next beam
// position so that they change on the same edge as the counters.
module rtg_status_flags #(
   parameter int DW         = 9,
   parameter int LW         = 9,
   parameter int SET_LINE   = 241,
   parameter int CLEAR_LINE = 261,
   parameter int FLAG_DOT   = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] dot_n,
   input  logic [LW-1:0] line_n,
   input  logic          rd_clr,
   output logic          vblank_q,
   output logic          spr_clr_q
);

   localparam logic [DW-1:0] EV_DOT   = DW'(FLAG_DOT);
   localparam logic [LW-1:0] EV_SET   = LW'(SET_LINE);
   localparam logic [LW-1:0] EV_CLEAR = LW'(CLEAR_LINE);

   logic hit_set;
   logic hit_clear;

   assign hit_set   = (line_n == EV_SET)   && (dot_n == EV_DOT);
   assign hit_clear = (line_n == EV_CLEAR) && (dot_n == EV_DOT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vblank_q  <= 1'b0;
         spr_clr_q <= 1'b0;
      end else begin
         spr_clr_q <= hit_clear;
         if (hit_set)                  vblank_q <= 1'b1;
         else if (hit_clear || rd_clr) vblank_q <= 1'b0;
      end
   end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int DOTS_PER_LINE   = 341,
   parameter int LINES_PER_FRAME = 262,
   parameter int VISIBLE_LINES   = 240,
   parameter int FLAG_DOT        = 1,
   parameter bit SKIP_ODD        = 1'b1,
   localparam int DOT_W          = $clog2(DOTS_PER_LINE),
   localparam int LINE_W         = $clog2(LINES_PER_FRAME)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              render_en,
   input  logic              status_rd_clr,
   output logic [DOT_W-1:0]  dot,
   output logic [LINE_W-1:0] line,
   output logic              odd_frame,
   output logic              rgn_visible,
   output logic              rgn_post,
   output logic              rgn_vblank,
   output logic              rgn_pre,
   output logic              vblank_flag,
   output logic              sprite_flags_clr
);

   localparam int VBLANK_LINE = VISIBLE_LINES + 1;
   localparam int PRE_LINE    = LINES_PER_FRAME - 1;

   // Elaboration-time parameter checks.
   generate
      if (DOTS_PER_LINE < 4) begin : g_bad_dots
         $error("DOTS_PER_LINE must be at least 4");
      end
      if (LINES_PER_FRAME < VISIBLE_LINES + 3) begin : g_bad_lines
         $error("LINES_PER_FRAME must leave post, blank and preparation lines");
      end
      if (FLAG_DOT < 0 || FLAG_DOT > DOTS_PER_LINE - 3) begin : g_bad_flag
         $error("FLAG_DOT must lie inside the shortened line");
      end
   endgenerate

   logic [DOT_W-1:0]  dot_n;
   logic [LINE_W-1:0] line_n;
   region_e           region;

   rtg_beam_counter #(
      .DOTS     (DOTS_PER_LINE),
      .LINES    (LINES_PER_FRAME),
      .SKIP_ODD (SKIP_ODD),
      .DW       (DOT_W),
      .LW       (LINE_W)
   ) u_beam (
      .clk       (clk),
      .rst_n     (rst_n),
      .render_en (render_en),
      .dot_q     (dot),
      .line_q    (line),
      .odd_q     (odd_frame),
      .dot_n     (dot_n),
      .line_n    (line_n)
   );

   rtg_region_decode #(
      .LINES   (LINES_PER_FRAME),
      .VISIBLE (VISIBLE_LINES),
      .LW      (LINE_W)
   ) u_region (
      .line_q     (line),
      .region     (region),
      .is_visible (rgn_visible),
      .is_post    (rgn_post),
      .is_vblank  (rgn_vblank),
      .is_pre     (rgn_pre)
   );

   rtg_status_flags #(
      .DW         (DOT_W),
      .LW         (LINE_W),
      .SET_LINE   (VBLANK_LINE),
      .CLEAR_LINE (PRE_LINE),
      .FLAG_DOT   (FLAG_DOT)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .dot_n     (dot_n),
      .line_n    (line_n),
      .rd_clr    (status_rd_clr),
      .vblank_q  (vblank_flag),
      .spr_clr_q (sprite_flags_clr)
   );

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
   parameter int DOTS     = 341,
   parameter int LINES    = 262,
   parameter int VISIBLE  = 240,
   parameter int FLAG_DOT = 1,
   parameter int DW       = 9,
   parameter int LW       = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          render_en,
   input logic          status_rd_clr,
   input logic [DW-1:0] dot,
   input logic [LW-1:0] line,
   input logic          odd_frame,
   input logic          rgn_visible,
   input logic          rgn_post,
   input logic          rgn_vblank,
   input logic          rgn_pre,
   input logic          vblank_flag,
   input logic          sprite_flags_clr
);

   localparam logic [DW-1:0] C_LAST  = DW'(DOTS - 1);
   localparam logic [DW-1:0] C_SHORT = DW'(DOTS - 2);
   localparam logic [DW-1:0] C_FLAG  = DW'(FLAG_DOT);
   localparam logic [LW-1:0] C_VB    = LW'(VISIBLE + 1);
   localparam logic [LW-1:0] C_PRE   = LW'(LINES - 1);

   a_r1_dot_range: assert property (@(posedge clk) disable iff (!rst_n)
      dot <= C_LAST);

   a_r1_dot_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dot != '0) |-> (dot == $past(dot) + 1'b1));

   a_r2_line_moves_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (line != $past(line)) |-> (dot == '0));

   a_r4_one_region: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({rgn_visible, rgn_post, rgn_vblank, rgn_pre}) == 1);

   a_r5_set_point: assert property (@(posedge clk) disable iff (!rst_n)
      (line == C_VB && dot == C_FLAG) |-> vblank_flag);

   a_r5_rise_only_there: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vblank_flag) |-> (line == C_VB && dot == C_FLAG));

   a_r7_clear_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      sprite_flags_clr |-> (!vblank_flag && line == C_PRE && dot == C_FLAG));

   a_r9_short_needs_odd_render: assert property (@(posedge clk) disable iff (!rst_n)
      (line == '0 && dot == '0 && $past(line) == C_PRE && $past(dot) == C_SHORT)
      |-> ($past(odd_frame) && $past(render_en)));

   a_r10_full_line: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(line) == C_PRE && $past(dot) == C_SHORT
       && !($past(odd_frame) && $past(render_en))) |-> (dot == C_LAST));

   a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(status_rd_clr) && !(line == C_VB && dot == C_FLAG)) |-> !vblank_flag);

endmodule

bind raster_timing_gen rtg_checker #(
   .DOTS     (DOTS_PER_LINE),
   .LINES    (LINES_PER_FRAME),
   .VISIBLE  (VISIBLE_LINES),
   .FLAG_DOT (FLAG_DOT),
   .DW       (DOT_W),
   .LW       (LINE_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .render_en        (render_en),
   .status_rd_clr    (status_rd_clr),
   .dot              (dot),
   .line             (line),
   .odd_frame        (odd_frame),
   .rgn_visible      (rgn_visible),
   .rgn_post         (rgn_post),
   .rgn_vblank       (rgn_vblank),
   .rgn_pre          (rgn_pre),
   .vblank_flag      (vblank_flag),
   .sprite_flags_clr (sprite_flags_clr)
);

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;

   localparam int D   = 12;
   localparam int L   = 10;
   localparam int V   = 6;
   localparam int FD  = 1;
   localparam int DW  = $clog2(D);
   localparam int LW  = $clog2(L);
   localparam int VB  = V + 1;
   localparam int PRE = L - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          render_en;
   logic          status_rd_clr;
   logic [DW-1:0] dot;
   logic [LW-1:0] line;
   logic          odd_frame, rgn_visible, rgn_post, rgn_vblank, rgn_pre;
   logic          vblank_flag, sprite_flags_clr;

   always #2 clk = ~clk;

   raster_timing_gen #(
      .DOTS_PER_LINE   (D),
      .LINES_PER_FRAME (L),
      .VISIBLE_LINES   (V),
      .FLAG_DOT        (FD),
      .SKIP_ODD        (1'b1)
   ) u0 (
      .clk              (clk),
      .rst_n            (rst_n),
      .render_en        (render_en),
      .status_rd_clr    (status_rd_clr),
      .dot              (dot),
      .line             (line),
      .odd_frame        (odd_frame),
      .rgn_visible      (rgn_visible),
      .rgn_post         (rgn_post),
      .rgn_vblank       (rgn_vblank),
      .rgn_pre          (rgn_pre),
      .vblank_flag      (vblank_flag),
      .sprite_flags_clr (sprite_flags_clr)
   );

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;
   int  e_dot, e_line, e_odd, e_vbl, e_clr, fcount;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, model the edge, compare after it.
   task automatic step(input bit ren, input bit rdc);
      int  nd, nl, no;
      bit  was_short, skipped, set_ev;
      string vtag, dtag;
      render_en     = ren;
      status_rd_clr = rdc;
      nd = e_dot + 1; nl = e_line; no = e_odd;
      was_short = (e_line == PRE) && (e_dot == D - 2);
      skipped   = was_short && e_odd == 1 && ren;
      if (skipped || e_dot == D - 1) begin
         nd = 0;
         if (e_line == PRE) begin nl = 0; no = 1 - e_odd; end
         else nl = e_line + 1;
      end
      set_ev = (nl == VB) && (nd == FD);
      if (set_ev)                          e_vbl = 1;
      else if ((nl == PRE && nd == FD) || rdc) e_vbl = 0;
      e_clr = (nl == PRE && nd == FD) ? 1 : 0;
      if (set_ev && rdc)            vtag = "R12 vblank set beats clear";
      else if (set_ev)              vtag = "R5 vblank set";
      else if (nl == PRE && nd == FD) vtag = "R6 vblank clear";
      else if (rdc)                 vtag = "R11 read clear";
      else                          vtag = "R5 vblank hold";
      if (was_short) dtag = skipped ? "R9 short line dot" : "R10 full line dot";
      else           dtag = "R1 dot";
      if (nl == 0 && nd == 0) fcount++;
      e_dot = nd; e_line = nl; e_odd = no;
      @(posedge clk);
      @(negedge clk);
      chk(dtag, int'(dot), e_dot);
      chk("R2 line", int'(line), e_line);
      chk("R8 parity", int'(odd_frame), e_odd);
      chk(vtag, int'(vblank_flag), e_vbl);
      chk("R7 sprite clear strobe", int'(sprite_flags_clr), e_clr);
      chk("R4 visible", int'(rgn_visible), (e_line < V) ? 1 : 0);
      chk("R4 post", int'(rgn_post), (e_line == V) ? 1 : 0);
      chk("R4 vblank", int'(rgn_vblank), (e_line > V && e_line < PRE) ? 1 : 0);
      chk("R4 pre", int'(rgn_pre), (e_line == PRE) ? 1 : 0);
   endtask

   initial begin
      rst_n = 1'b0; render_en = 1'b0; status_rd_clr = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R3 reset dot", int'(dot), 0);
      chk("R3 reset line", int'(line), PRE);
      chk("R3 reset parity", int'(odd_frame), 0);
      chk("R3 reset vblank", int'(vblank_flag), 0);
      e_dot = 0; e_line = PRE; e_odd = 0; e_vbl = 0; e_clr = 0; fcount = 0;
      rst_n = 1'b1;
      for (int c = 0; c < 1000; c++) begin
         bit ren, rdc;
         ren = ((fcount >> 1) & 1) == 0;
         rdc = (c % 37 == 5)
               || (fcount == 2 && e_line == VB && e_dot == FD - 1)
               || (fcount == 4 && e_line == VB && e_dot == FD + 2);
         step(ren, rdc);
      end
      chk("R8 frames seen", (fcount >= 7) ? 1 : 0, 1);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule